// File: doc/BRIEF.md
# Hold-Grant Crossbar Allocator

This block decides, once per cycle, which requesting sources may send into which memory-controller ports of a single crossbar router. It takes a request matrix of `NUM_IN` sources by `NUM_OUT` destinations, plus the DRAM row address carried by each source's head request. It returns a registered grant matrix in which every source and every destination appears at most once. Matching is separable and input-first: every source first picks one of the destinations it wants, and every destination then picks one of the sources that chose it. Both stages use round-robin arbiters.

Plain round-robin interleaves the streams from many sources, and that interleaving breaks up runs of same-row DRAM accesses. To counter this, the allocator can keep a pair connected across cycles. In unconditional hold mode, any pair granted last cycle that is still requesting is granted again, whatever else is pending. In hash-gated hold mode, the pair is held only if a 4-bit fold of the new request's row matches the fold stored for that destination at its last grant. A held grant does not move the round-robin pointers, so the other sources get their normal turn once the hold drops.

Top module: `hga_allocator`

## Requirements
- R1: After a synchronous reset, the grant matrix is all zero, no pair is held, every input arbiter favours output 0 first, and every output arbiter favours input 0 first.
- R2: The grant matrix is registered, so grants for a request matrix appear one clock later. Only requested pairs can be granted, and a cycle with no requests gives no grants. Pair (i,o) sits at bit i*NUM_OUT+o of both matrices.
- R3: In each cycle, at most one grant is set in each input's row and at most one in each output's column.
- R4: Matching is a single separable input-first pass. Each input nominates one of its eligible outputs. Each output then grants one of its nominators. An input whose nominee went to another input receives nothing that cycle, even if some other output it wanted stays idle.
- R5: Both arbiter stages are round-robin. The search starts just after the most recently served index, so the last winner has the lowest priority. A pointer moves only on a grant that was not forced by a hold.
- R6: With mode_sel = 1, a pair granted in the previous cycle that is requesting again is forced. All other requests in its input row and its output column are dropped, so the pair is granted again.
- R7: With mode_sel = 2, a previously granted pair that is requesting again is forced only when the fold of its row address equals the stored fold for that output. The fold is row[3:0] ^ row[7:4] ^ row[11:8], and source i's row sits at row_addr bits i*12 +: 12. On a mismatch the pair competes through plain round-robin.
- R8: Each output stores the fold of the row address of the input it granted. The stored fold is refreshed on every grant of that output, in every mode.
- R9: A pair counts as held only if it was granted in the immediately preceding cycle. A pair that is not granted in some cycle (for example because it stopped requesting) loses its hold.
- R10: mode_sel = 0 and mode_sel = 3 both give plain round-robin with no forcing, even when a previously granted pair is requesting again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | 0 or 3 round-robin, 1 unconditional hold, 2 hash-gated hold |
| req_mat | input | NUM_IN*NUM_OUT | Request matrix, bit i*NUM_OUT+o means input i wants output o |
| row_addr | input | NUM_IN*ROW_W | Row address of each input's head request, ROW_W bits per input |
| grant_mat | output | NUM_IN*NUM_OUT | Registered grant matrix, same bit layout as req_mat |

## Verification
The directed part goes after the cases where the hold logic and the arbiters disagree. In one, a held pair must win a column that round-robin would give to another input; a design that only prioritised the hold, without masking the rest of the row and column, would grant the rival instead. In another, the fold matches only because the stored fold was refreshed on an intervening grant; a design that never updated it would fall back to round-robin. Separate cases show that a dropped hold does not revive, and that mode 3 must not hold. A long sweep over mixed modes, request densities and colliding row folds compares every grant matrix against an arithmetic model and checks row and column exclusivity each cycle, which exposes pointers that advance on forced grants or start from the wrong index.

// File: rtl/hga_pkg.sv
package hga_pkg;

   typedef enum logic [1:0] {
      HGA_MODE_RR     = 2'd0,
      HGA_MODE_HOLD   = 2'd1,
      HGA_MODE_HASH   = 2'd2,
      HGA_MODE_RR_ALT = 2'd3
   } hga_mode_e;

endpackage

// File: rtl/hga_rr_arbiter.sv
// Round-robin picker with a registered last-served pointer.
module hga_rr_arbiter #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] req,
   input  logic         adv,
   output logic [N-1:0] gnt
);
   localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

   logic [PTR_W-1:0] last_q;
   logic [PTR_W-1:0] win_idx;
   int               probe;
   logic             found;

   always_comb begin
      gnt     = '0;
      found   = 1'b0;
      win_idx = last_q;
      probe   = 0;
      for (int k = 1; k <= N; k++) begin
         probe = (int'(last_q) + k) % N;
         if (!found && req[probe]) begin
            gnt[probe] = 1'b1;
            win_idx    = PTR_W'(probe);
            found      = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         last_q <= PTR_W'(N - 1);
      end else if (adv && found) begin
         last_q <= win_idx;
      end
   end

endmodule

// File: rtl/hga_hold_filter.sv
// Decides which held pairs are forced and clears their row/column rivals.
module hga_hold_filter
   import hga_pkg::*;
#(
   parameter int NUM_IN  = 4,
   parameter int NUM_OUT = 3
) (
   input  hga_mode_e                    mode,
   input  logic [NUM_IN*NUM_OUT-1:0]    req,
   input  logic [NUM_IN*NUM_OUT-1:0]    held,
   input  logic [NUM_IN*NUM_OUT-1:0]    hash_eq,
   output logic [NUM_IN*NUM_OUT-1:0]    forced,
   output logic [NUM_IN*NUM_OUT-1:0]    eligible,
   output logic [NUM_IN-1:0]            row_forced,
   output logic [NUM_OUT-1:0]           col_forced
);
   logic hold_on;
   logic hash_on;

   assign hold_on = (mode == HGA_MODE_HOLD);
   assign hash_on = (mode == HGA_MODE_HASH);

   for (genvar k = 0; k < NUM_IN*NUM_OUT; k++) begin : g_force
      assign forced[k] = req[k] & held[k] & (hold_on | (hash_on & hash_eq[k]));
   end

   for (genvar i = 0; i < NUM_IN; i++) begin : g_row
      assign row_forced[i] = |forced[i*NUM_OUT +: NUM_OUT];
   end

   for (genvar o = 0; o < NUM_OUT; o++) begin : g_col
      logic [NUM_IN-1:0] col_bits;
      for (genvar i = 0; i < NUM_IN; i++) begin : g_bit
         assign col_bits[i] = forced[i*NUM_OUT + o];
      end
      assign col_forced[o] = |col_bits;
   end

   for (genvar i = 0; i < NUM_IN; i++) begin : g_elig_i
      for (genvar o = 0; o < NUM_OUT; o++) begin : g_elig_o
         localparam int K = i*NUM_OUT + o;
         assign eligible[K] = forced[K] |
                              (req[K] & ~row_forced[i] & ~col_forced[o]);
      end
   end

endmodule

// File: rtl/hga_allocator.sv
module hga_allocator
   import hga_pkg::*;
#(
   parameter int NUM_IN  = 4,
   parameter int NUM_OUT = 3,
   parameter int ROW_W   = 12,
   parameter int HASH_W  = 4
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [1:0]                  mode_sel,
   input  logic [NUM_IN*NUM_OUT-1:0]   req_mat,
   input  logic [NUM_IN*ROW_W-1:0]     row_addr,
   output logic [NUM_IN*NUM_OUT-1:0]   grant_mat
);
   localparam int PAIRS = NUM_IN * NUM_OUT;
   localparam int FOLDS = ROW_W / HASH_W;

   if (NUM_IN < 2 || NUM_OUT < 2) begin : g_bad_size
      $error("hga_allocator needs at least two inputs and two outputs");
   end
   if (HASH_W < 1 || (ROW_W % HASH_W) != 0) begin : g_bad_hash
      $error("hga_allocator: ROW_W must be a multiple of HASH_W");
   end

   hga_mode_e mode;
   assign mode = hga_mode_e'(mode_sel);

   logic [PAIRS-1:0]          grant_q;
   logic [PAIRS-1:0]          next_grant;
   logic [PAIRS-1:0]          hash_eq;
   logic [PAIRS-1:0]          forced;
   logic [PAIRS-1:0]          eligible;
   logic [PAIRS-1:0]          in_pick;
   logic [NUM_IN-1:0]         row_forced;
   logic [NUM_OUT-1:0]        col_forced;
   logic [NUM_IN-1:0]         in_adv;
   logic [NUM_OUT-1:0]        out_adv;
   logic [HASH_W-1:0]         row_hash [NUM_IN];
   logic [NUM_OUT*HASH_W-1:0] last_hash_flat;

   // Fold each input's row address into a short tag.
   for (genvar i = 0; i < NUM_IN; i++) begin : g_fold
      logic [HASH_W-1:0] acc;
      always_comb begin
         acc = '0;
         for (int f = 0; f < FOLDS; f++) begin
            acc = acc ^ row_addr[i*ROW_W + f*HASH_W +: HASH_W];
         end
      end
      assign row_hash[i] = acc;
   end

   for (genvar i = 0; i < NUM_IN; i++) begin : g_eq_i
      for (genvar o = 0; o < NUM_OUT; o++) begin : g_eq_o
         assign hash_eq[i*NUM_OUT + o] =
            (row_hash[i] == last_hash_flat[o*HASH_W +: HASH_W]);
      end
   end

   hga_hold_filter #(
      .NUM_IN (NUM_IN),
      .NUM_OUT(NUM_OUT)
   ) u_filter (
      .mode      (mode),
      .req       (req_mat),
      .held      (grant_q),
      .hash_eq   (hash_eq),
      .forced    (forced),
      .eligible  (eligible),
      .row_forced(row_forced),
      .col_forced(col_forced)
   );

   // Input stage: one nomination per input.
   for (genvar i = 0; i < NUM_IN; i++) begin : g_in_arb
      hga_rr_arbiter #(.N(NUM_OUT)) u_arb (
         .clk(clk),
         .rst(rst),
         .req(eligible[i*NUM_OUT +: NUM_OUT]),
         .adv(in_adv[i]),
         .gnt(in_pick[i*NUM_OUT +: NUM_OUT])
      );
      assign in_adv[i] = (|next_grant[i*NUM_OUT +: NUM_OUT]) & ~row_forced[i];
   end

   // Output stage: one winner per output, plus the fold store.
   for (genvar o = 0; o < NUM_OUT; o++) begin : g_out_arb
      logic [NUM_IN-1:0] col_req;
      logic [NUM_IN-1:0] col_gnt;
      logic [HASH_W-1:0] win_hash;
      logic [HASH_W-1:0] hash_q;

      for (genvar i = 0; i < NUM_IN; i++) begin : g_tp
         assign col_req[i]                = in_pick[i*NUM_OUT + o];
         assign next_grant[i*NUM_OUT + o] = col_gnt[i];
      end

      hga_rr_arbiter #(.N(NUM_IN)) u_arb (
         .clk(clk),
         .rst(rst),
         .req(col_req),
         .adv(out_adv[o]),
         .gnt(col_gnt)
      );
      assign out_adv[o] = (|col_gnt) & ~col_forced[o];

      always_comb begin
         win_hash = '0;
         for (int i = 0; i < NUM_IN; i++) begin
            if (col_gnt[i]) win_hash = win_hash | row_hash[i];
         end
      end

      always_ff @(posedge clk) begin
         if (rst) begin
            hash_q <= '0;
         end else if (|col_gnt) begin
            hash_q <= win_hash;
         end
      end
      assign last_hash_flat[o*HASH_W +: HASH_W] = hash_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         grant_q <= '0;
      end else begin
         grant_q <= next_grant;
      end
   end

   assign grant_mat = grant_q;

endmodule

// File: rtl/hga_allocator_checker.sv
module hga_allocator_checker #(
   parameter int NUM_IN  = 4,
   parameter int NUM_OUT = 3,
   parameter int ROW_W   = 12,
   parameter int HASH_W  = 4
) (
   input logic                        clk,
   input logic                        rst,
   input logic [1:0]                  mode_sel,
   input logic [NUM_IN*NUM_OUT-1:0]   req_mat,
   input logic [NUM_IN*ROW_W-1:0]     row_addr,
   input logic [NUM_IN*NUM_OUT-1:0]   grant_mat,
   input logic [NUM_OUT*HASH_W-1:0]   last_hash
);
   localparam int FOLDS = ROW_W / HASH_W;

   logic [HASH_W-1:0] tag [NUM_IN];

   for (genvar i = 0; i < NUM_IN; i++) begin : g_tag
      logic [HASH_W-1:0] t;
      always_comb begin
         t = '0;
         for (int f = 0; f < FOLDS; f++) t = t ^ row_addr[i*ROW_W + f*HASH_W +: HASH_W];
      end
      assign tag[i] = t;
   end

   for (genvar i = 0; i < NUM_IN; i++) begin : g_row
      assert_row_single_R3: assert property (@(posedge clk) disable iff (rst)
         $onehot0(grant_mat[i*NUM_OUT +: NUM_OUT]));
   end

   for (genvar o = 0; o < NUM_OUT; o++) begin : g_col
      logic [NUM_IN-1:0] col;
      for (genvar i = 0; i < NUM_IN; i++) begin : g_b
         assign col[i] = grant_mat[i*NUM_OUT + o];
      end
      assert_col_single_R3: assert property (@(posedge clk) disable iff (rst)
         $onehot0(col));
   end

   for (genvar i = 0; i < NUM_IN; i++) begin : g_pair_i
      for (genvar o = 0; o < NUM_OUT; o++) begin : g_pair_o
         localparam int K = i*NUM_OUT + o;

         assert_grant_was_requested_R2: assert property (@(posedge clk) disable iff (rst)
            grant_mat[K] |-> $past(req_mat[K]));

         assert_hold_regrant_R6: assert property (@(posedge clk) disable iff (rst)
            (mode_sel == 2'd1 && req_mat[K] && grant_mat[K]) |=> grant_mat[K]);

         assert_hash_regrant_R7: assert property (@(posedge clk) disable iff (rst)
            (mode_sel == 2'd2 && req_mat[K] && grant_mat[K] &&
             tag[i] == last_hash[o*HASH_W +: HASH_W]) |=> grant_mat[K]);
      end
   end

endmodule

bind hga_allocator hga_allocator_checker #(
   .NUM_IN (NUM_IN),
   .NUM_OUT(NUM_OUT),
   .ROW_W  (ROW_W),
   .HASH_W (HASH_W)
) u_checker (
   .clk      (clk),
   .rst      (rst),
   .mode_sel (mode_sel),
   .req_mat  (req_mat),
   .row_addr (row_addr),
   .grant_mat(grant_mat),
   .last_hash(last_hash_flat)
);

// File: tb/hga_allocator_test.sv
`timescale 1ns/100ps
module hga_allocator_test;
   localparam int C  = 3;
   localparam int M  = 2;
   localparam int RW = 12;
   localparam int P  = C * M;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [1:0]    mode_sel = 2'd0;
   logic [P-1:0]  req_mat = '0;
   logic [C*RW-1:0] row_addr = '0;
   logic [P-1:0]  grant_mat;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   hga_allocator #(.NUM_IN(C), .NUM_OUT(M), .ROW_W(RW), .HASH_W(4)) uut (
      .clk(clk), .rst(rst), .mode_sel(mode_sel), .req_mat(req_mat),
      .row_addr(row_addr), .grant_mat(grant_mat)
   );

   // Arithmetic model state
   int ip [C];
   int op [M];
   bit hold_m [C][M];
   int hs [M];

   function automatic int fold(input logic [11:0] r);
      return int'(r[3:0] ^ r[7:4] ^ r[11:8]);
   endfunction

   task automatic model_reset();
      for (int i = 0; i < C; i++) ip[i] = M - 1;
      for (int o = 0; o < M; o++) begin op[o] = C - 1; hs[o] = 0; end
      for (int i = 0; i < C; i++) for (int o = 0; o < M; o++) hold_m[i][o] = 1'b0;
   endtask

   task automatic model_step(input int md, input logic [P-1:0] rq,
                             input logic [C*RW-1:0] rw, output logic [P-1:0] g);
      bit frc [C][M];
      bit eff [C][M];
      bit rf [C];
      bit cf [M];
      int pick [C];
      int h [C];
      for (int i = 0; i < C; i++) h[i] = fold(rw[i*RW +: RW]);
      for (int i = 0; i < C; i++) rf[i] = 1'b0;
      for (int o = 0; o < M; o++) cf[o] = 1'b0;
      for (int i = 0; i < C; i++)
         for (int o = 0; o < M; o++) begin
            frc[i][o] = rq[i*M+o] && hold_m[i][o] &&
                        (md == 1 || (md == 2 && h[i] == hs[o]));
            if (frc[i][o]) begin rf[i] = 1'b1; cf[o] = 1'b1; end
         end
      for (int i = 0; i < C; i++)
         for (int o = 0; o < M; o++)
            eff[i][o] = frc[i][o] || (rq[i*M+o] && !rf[i] && !cf[o]);
      for (int i = 0; i < C; i++) begin
         pick[i] = -1;
         for (int k = 1; k <= M; k++) begin
            int o;
            o = (ip[i] + k) % M;
            if (pick[i] < 0 && eff[i][o]) pick[i] = o;
         end
      end
      g = '0;
      for (int o = 0; o < M; o++) begin
         int win;
         win = -1;
         for (int k = 1; k <= C; k++) begin
            int i;
            i = (op[o] + k) % C;
            if (win < 0 && pick[i] == o) win = i;
         end
         if (win >= 0) begin
            g[win*M+o] = 1'b1;
            hs[o] = h[win];
            if (!frc[win][o]) begin op[o] = win; ip[win] = o; end
         end
      end
      for (int i = 0; i < C; i++) for (int o = 0; o < M; o++) hold_m[i][o] = g[i*M+o];
   endtask

   task automatic check(input string tag, input logic [P-1:0] act, input logic [P-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: grant=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic check_excl();
      int n;
      for (int i = 0; i < C; i++) begin
         n = 0;
         for (int o = 0; o < M; o++) n += int'(grant_mat[i*M+o]);
         checks++;
         if (n > 1) begin errors++; $display("FAIL R3 row %0d: grants=%0d expected<=1", i, n); end
      end
      for (int o = 0; o < M; o++) begin
         n = 0;
         for (int i = 0; i < C; i++) n += int'(grant_mat[i*M+o]);
         checks++;
         if (n > 1) begin errors++; $display("FAIL R3 col %0d: grants=%0d expected<=1", o, n); end
      end
   endtask

   // Drive at a falling edge, let one rising edge register, return at the next falling edge.
   task automatic step(input int md, input logic [P-1:0] rq,
                       input logic [C*RW-1:0] rw, output logic [P-1:0] e);
      mode_sel = md[1:0];
      req_mat  = rq;
      row_addr = rw;
      model_step(md, rq, rw, e);
      @(negedge clk);
   endtask

   function automatic logic [C*RW-1:0] rows(input logic [11:0] a, b, c);
      return {c, b, a};
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : stim
      logic [P-1:0] e;
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      check("R1 grant clear after reset", grant_mat, '0);

      step(0, 6'b111111, '0, e);
      check("R4 model", grant_mat, e);
      check("R4 first pass from reset", grant_mat, 6'b000001);
      step(0, 6'b111111, '0, e);
      check("R5 rotated priorities", grant_mat, 6'b000110);
      check("R5 model", grant_mat, e);

      for (int n = 0; n < 3; n++) begin
         step(1, 6'b111111, '0, e);
         check("R6 held pairs regranted", grant_mat, 6'b000110);
      end
      step(1, 6'b010101, '0, e);
      check("R6 held pair keeps column", grant_mat, 6'b000100);
      step(1, 6'b100000, '0, e);
      check("R2 single request", grant_mat, 6'b100000);
      step(1, 6'b010100, '0, e);
      check("R9 released hold not forced", grant_mat, 6'b010000);

      step(2, 6'b010001, rows(12'h000, 12'h000, 12'h111), e);
      check("R7 fold mismatch no hold", grant_mat, 6'b000001);
      step(2, 6'b010001, rows(12'h303, 12'h000, 12'h000), e);
      check("R7 fold match holds", grant_mat, 6'b000001);
      step(2, 6'b000001, rows(12'h0F0, 12'h000, 12'h000), e);
      check("R8 regrant new row", grant_mat, 6'b000001);
      step(2, 6'b010001, rows(12'h00F, 12'h000, 12'h000), e);
      check("R8 refreshed fold holds", grant_mat, 6'b000001);
      step(3, 6'b010001, rows(12'h00F, 12'h000, 12'h000), e);
      check("R10 mode 3 is round-robin", grant_mat, 6'b010000);
      step(1, 6'b000000, '0, e);
      check("R2 no request no grant", grant_mat, 6'b000000);
      step(1, 6'b010001, '0, e);
      check("R9 hold dropped after idle", grant_mat, 6'b000001);

      begin
         int md;
         md = 0;
         for (int n = 0; n < 4000; n++) begin
            logic [P-1:0] rq;
            logic [C*RW-1:0] rw;
            if (n % 16 == 0) md = int'($urandom % 4);
            rq = P'($urandom);
            if (n % 5 == 0) rq = rq | P'($urandom);
            for (int i = 0; i < C; i++) begin
               if ($urandom % 3 == 0) rw[i*RW +: RW] = 12'($urandom);
               else rw[i*RW +: RW] = 12'(($urandom % 4) * 12'h111);
            end
            step(md, rq, rw, e);
            check($sformatf("R5 R6 R7 sweep mode %0d", md), grant_mat, e);
            check_excl();
         end
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule